// File: doc/BRIEF.md
# Multi-Mode Sample Buffer

This block stores three-axis acceleration samples in a byte-organised circular store of 252 bytes and hands them back one byte at a time through a single read strobe. A resolution input selects how each sample is packed: narrow samples keep only the top eight bits of each axis (three bytes per sample), wide samples keep all twelve bits, left-justified in two bytes per axis (six bytes per sample). Capacity in samples therefore changes with the resolution.

Three fill policies are available. A queue policy stops accepting samples once the store is full. A streaming policy keeps the newest samples by evicting the oldest one. A capture policy keeps only a short history of the most recent samples until another engine raises a trigger, after which the store fills to capacity and holds. A watermark flag tells the host that enough samples are waiting, and a full flag reports that no further sample fits.

Top module: `accel_sample_buffer`

## Requirements
- R1: After reset, level, wmark, full and rd_byte are all 0.
- R2: With res_hi = 0 a sample occupies 3 bytes and at most 84 samples are held; with res_hi = 1 a sample occupies 6 bytes and at most 41 are held. full is 1 exactly when level equals the capacity of the current resolution.
- R3: Bytes of a sample come out in axis order X, Y, Z. For res_hi = 0 each axis gives one byte, axis[11:4]. For res_hi = 1 each axis gives {axis[3:0],4'b0000} first and then axis[11:4].
- R4: With buf_mode 2'b00 (and 2'b11, which behaves the same), a sample that arrives while full was 1 at the start of that cycle is dropped and stored data is unchanged.
- R5: With buf_mode 2'b01, a sample that arrives while full is stored and the oldest sample, including any unread rest of a partly read sample, is discarded; level stays at capacity.
- R6: wmark is 1 when buf_mode is not 2'b10, wm_level is non-zero and level >= wm_level; it is 0 otherwise, and falls as soon as reads take level below wm_level.
- R7: With buf_mode 2'b10 and no trigger seen, the store holds at most min(wm_level, capacity) of the newest samples, evicting the oldest to admit a new one; with wm_level = 0 no sample is stored.
- R8: Once trig_evt is 1 at a clock edge in buf_mode 2'b10, that sample and later ones are stored as in R4 until the store is full, and full rises.
- R9: Each rd_strobe on a non-empty store yields the next byte on rd_byte from the following cycle, held until the next strobe; level drops by one when the last byte of the oldest sample is read.
- R10: rd_strobe on an empty store sets rd_byte to 0 and does not advance the read position.
- R11: A cycle in which res_hi or buf_mode differs from its previous value empties the store, forgets any trigger, drops a sample arriving in that cycle and ignores a read.
- R12: A read and a sample arrival in the same cycle both take effect; a queue-mode sample arriving when full is dropped even if that cycle's read finishes the oldest sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | New sample present on the axis inputs |
| smp_x | input | AXW | X-axis sample |
| smp_y | input | AXW | Y-axis sample |
| smp_z | input | AXW | Z-axis sample |
| res_hi | input | 1 | 0: narrow 3-byte samples, 1: wide 6-byte samples |
| buf_mode | input | 2 | 00/11 queue, 01 streaming, 10 capture |
| wm_level | input | CW | Sample threshold for watermark and capture history |
| trig_evt | input | 1 | Trigger from another engine |
| rd_strobe | input | 1 | Pop one byte |
| rd_byte | output | 8 | Byte returned by the last read |
| level | output | CW | Samples held, including a partly read one |
| wmark | output | 1 | Watermark flag |
| full | output | 1 | No room for another sample |

## Verification
A wrong write or read pointer shows as a byte on rd_byte that differs from the reference stream at the first read that touches the corrupted slot, so the bench compares rd_byte, level, wmark and full with a behavioural queue model on every cycle. A miscounted level shows on level and full in the very cycle after the faulty update, while a wrong eviction in streaming or capture mode stays hidden until the affected sample is read, which the directed cases force within a few cycles by reading right after each eviction. A trigger latch that is not cleared on a mode change would show only after the next capture run overflows its history limit, so that case is reached deliberately.

// File: rtl/smpbuf_pkg.sv
package smpbuf_pkg;
   typedef enum logic [1:0] {
      BM_FIFO     = 2'd0,
      BM_STREAM   = 2'd1,
      BM_TRIG     = 2'd2,
      BM_FIFO_ALT = 2'd3
   } buf_mode_e;

   localparam int BYTE_W = 8;
   localparam int BPS_LO = 3;   // bytes per narrow sample
   localparam int BPS_HI = 6;   // bytes per wide sample
endpackage

// File: rtl/smpbuf_packer.sv
module smpbuf_packer
   import smpbuf_pkg::*;
#(
   parameter int AXW = 12
) (
   input  logic [3*AXW-1:0]         axes,     // {z, y, x}
   input  logic                     res_hi,
   output logic [BPS_HI*BYTE_W-1:0] lanes
);
   localparam int LOW = AXW - BYTE_W;

   logic [BYTE_W-1:0] hi_b [3];
   logic [BYTE_W-1:0] lo_b [3];

   for (genvar g = 0; g < 3; g++) begin : g_axis
      assign hi_b[g] = axes[g*AXW + AXW - 1 -: BYTE_W];
      if (LOW == BYTE_W) begin : g_full_low
         assign lo_b[g] = axes[g*AXW +: BYTE_W];
      end else begin : g_pad_low
         assign lo_b[g] = {axes[g*AXW +: LOW], {(BYTE_W-LOW){1'b0}}};
      end
   end

   always_comb begin
      lanes = '0;
      for (int g = 0; g < 3; g++) begin
         if (res_hi) begin
            lanes[(2*g)*BYTE_W   +: BYTE_W] = lo_b[g];
            lanes[(2*g+1)*BYTE_W +: BYTE_W] = hi_b[g];
         end else begin
            lanes[g*BYTE_W +: BYTE_W] = hi_b[g];
         end
      end
   end
endmodule

// File: rtl/smpbuf_store.sv
module smpbuf_store
   import smpbuf_pkg::*;
#(
   parameter int DEPTH = 252,
   parameter int PW    = $clog2(DEPTH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic                     wide,
   input  logic [PW-1:0]            waddr,
   input  logic [BPS_HI*BYTE_W-1:0] lanes,
   input  logic                     re,
   input  logic                     rclr,
   input  logic [PW-1:0]            raddr,
   output logic [BYTE_W-1:0]        rdata
);
   logic [BYTE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int k = 0; k < BPS_HI; k++) begin
         if (we && (wide || k < BPS_LO))
            mem[waddr + PW'(k)] <= lanes[k*BYTE_W +: BYTE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata <= '0;
      else if (rclr) rdata <= '0;
      else if (re)   rdata <= mem[raddr];
   end
endmodule

// File: rtl/smpbuf_ctrl.sv
module smpbuf_ctrl
   import smpbuf_pkg::*;
#(
   parameter int DEPTH  = 252,
   parameter int CAP_LO = 84,
   parameter int CAP_HI = 41,
   parameter int PW     = $clog2(DEPTH),
   parameter int CW     = $clog2(CAP_LO+1),
   parameter int SW     = $clog2(BPS_HI+1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_valid,
   input  logic          res_hi,
   input  logic [1:0]    mode,
   input  logic [CW-1:0] thresh,
   input  logic          trig_evt,
   input  logic          rd_strobe,
   output logic          we,
   output logic [PW-1:0] wr_ptr,
   output logic          re,
   output logic          rclr,
   output logic [PW-1:0] rd_ptr,
   output logic [CW-1:0] count,
   output logic          wmark,
   output logic          full
);
   buf_mode_e     mode_e;
   logic [1:0]    mode_q;
   logic          res_q, trg_q, flush;
   logic [SW-1:0] rd_sub, bps;
   logic [CW-1:0] cap_s, lim;
   logic [PW:0]   capb;
   logic [PW-1:0] base;
   logic          empty, at_cap, trg_now, take, disc, head_done;

   function automatic logic [PW-1:0] adv(input logic [PW-1:0] p,
                                         input logic [SW-1:0] n,
                                         input logic [PW:0]   top);
      logic [PW:0] s;
      s = {1'b0, p} + (PW+1)'(n);
      return (s >= top) ? PW'(s - top) : PW'(s);
   endfunction

   assign mode_e  = buf_mode_e'(mode);
   assign flush   = (mode != mode_q) || (res_hi != res_q);
   assign cap_s   = res_hi ? CW'(CAP_HI) : CW'(CAP_LO);
   assign bps     = res_hi ? SW'(BPS_HI) : SW'(BPS_LO);
   assign capb    = res_hi ? (PW+1)'(CAP_HI*BPS_HI) : (PW+1)'(CAP_LO*BPS_LO);
   assign empty   = (count == '0);
   assign at_cap  = (count == cap_s);
   assign trg_now = trg_q | trig_evt;
   assign lim     = (thresh < cap_s) ? thresh : cap_s;
   assign base    = rd_ptr - PW'(rd_sub);

   always_comb begin
      take = 1'b0;
      disc = 1'b0;
      if (!flush) begin
         unique case (mode_e)
            BM_STREAM: begin
               take = smp_valid;
               disc = smp_valid && at_cap;
            end
            BM_TRIG: begin
               if (trg_now) begin
                  take = smp_valid && !at_cap;
               end else begin
                  take = smp_valid && (thresh != '0);
                  disc = take && (count >= lim);
               end
            end
            default: take = smp_valid && !at_cap;
         endcase
      end
   end

   assign re        = rd_strobe && !empty && !flush;
   assign rclr      = rd_strobe && empty && !flush;
   assign head_done = disc || (re && (rd_sub == bps - SW'(1)));
   assign we        = take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         res_q  <= 1'b0;
         trg_q  <= 1'b0;
         wr_ptr <= '0;
         rd_ptr <= '0;
         rd_sub <= '0;
         count  <= '0;
      end else begin
         mode_q <= mode;
         res_q  <= res_hi;
         if (flush) begin
            trg_q  <= 1'b0;
            wr_ptr <= '0;
            rd_ptr <= '0;
            rd_sub <= '0;
            count  <= '0;
         end else begin
            if (trig_evt) trg_q <= 1'b1;
            if (take) wr_ptr <= adv(wr_ptr, bps, capb);
            if (head_done) begin
               rd_ptr <= adv(base, bps, capb);
               rd_sub <= '0;
            end else if (re) begin
               rd_ptr <= adv(rd_ptr, SW'(1), capb);
               rd_sub <= rd_sub + SW'(1);
            end
            count <= count + CW'(take) - CW'(head_done);
         end
      end
   end

   assign wmark = (mode_e != BM_TRIG) && (thresh != '0) && (count >= thresh);
   assign full  = at_cap;
endmodule

// File: rtl/accel_sample_buffer.sv
module accel_sample_buffer
   import smpbuf_pkg::*;
#(
   parameter int AXW        = 12,
   parameter int DEPTH      = 252,
   parameter int CAP_NARROW = 84,
   parameter int CAP_WIDE   = 41,
   localparam int PW        = $clog2(DEPTH),
   localparam int CW        = $clog2(CAP_NARROW+1),
   localparam int SW        = $clog2(BPS_HI+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [AXW-1:0]    smp_x,
   input  logic [AXW-1:0]    smp_y,
   input  logic [AXW-1:0]    smp_z,
   input  logic              res_hi,
   input  logic [1:0]        buf_mode,
   input  logic [CW-1:0]     wm_level,
   input  logic              trig_evt,
   input  logic              rd_strobe,
   output logic [BYTE_W-1:0] rd_byte,
   output logic [CW-1:0]     level,
   output logic              wmark,
   output logic              full
);
   if (AXW <= BYTE_W || AXW > 2*BYTE_W) begin : g_bad_axw
      $error("AXW must lie in 9..16");
   end
   if (CAP_NARROW*BPS_LO > DEPTH || CAP_WIDE*BPS_HI > DEPTH) begin : g_bad_cap
      $error("capacity exceeds store depth");
   end
   if (CAP_WIDE > CAP_NARROW || CAP_WIDE < 1) begin : g_bad_order
      $error("wide capacity must be 1..narrow capacity");
   end

   logic [BPS_HI*BYTE_W-1:0] lanes;
   logic                     we, re, rclr;
   logic [PW-1:0]            wr_ptr, rd_ptr;

   smpbuf_packer #(.AXW(AXW)) u_pack (
      .axes   ({smp_z, smp_y, smp_x}),
      .res_hi (res_hi),
      .lanes  (lanes)
   );

   smpbuf_ctrl #(
      .DEPTH (DEPTH), .CAP_LO(CAP_NARROW), .CAP_HI(CAP_WIDE),
      .PW    (PW),    .CW    (CW),         .SW    (SW)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .res_hi    (res_hi),
      .mode      (buf_mode),
      .thresh    (wm_level),
      .trig_evt  (trig_evt),
      .rd_strobe (rd_strobe),
      .we        (we),
      .wr_ptr    (wr_ptr),
      .re        (re),
      .rclr      (rclr),
      .rd_ptr    (rd_ptr),
      .count     (level),
      .wmark     (wmark),
      .full      (full)
   );

   smpbuf_store #(.DEPTH(DEPTH), .PW(PW)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .wide  (res_hi),
      .waddr (wr_ptr),
      .lanes (lanes),
      .re    (re),
      .rclr  (rclr),
      .raddr (rd_ptr),
      .rdata (rd_byte)
   );
endmodule

// File: rtl/smpbuf_chk.sv
module smpbuf_chk #(
   parameter int CAP_LO = 84,
   parameter int CAP_HI = 41,
   localparam int CW    = $clog2(CAP_LO+1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    buf_mode,
   input logic          res_hi,
   input logic          smp_valid,
   input logic          rd_strobe,
   input logic [CW-1:0] level,
   input logic          full,
   input logic [7:0]    rd_byte
);
   // R2: level never exceeds the capacity of a settled resolution
   a_r2_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(res_hi) |-> int'(level) <= (res_hi ? CAP_HI : CAP_LO));

   // R4: queue mode, full, no read -> nothing changes
   a_r4_fifo_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((buf_mode == 2'd0) && full && !rd_strobe && $stable(buf_mode) && $stable(res_hi))
      |=> $stable(level));

   // R5: streaming mode stays full while samples keep arriving
   a_r5_stream_full: assert property (@(posedge clk) disable iff (!rst_n)
      ((buf_mode == 2'd1) && full && smp_valid && $stable(buf_mode) && $stable(res_hi))
      |=> (full || !$stable(res_hi)));

   // R9: level moves by at most one sample per cycle
   a_r9_level_step: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(buf_mode) && $stable(res_hi))
      |=> ((int'(level) <= int'($past(level)) + 1) && (int'($past(level)) <= int'(level) + 1)));

   // R10: read of an empty store returns zero
   a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      ((level == '0) && rd_strobe && $stable(buf_mode) && $stable(res_hi)) |=> (rd_byte == 8'd0));

   // R11: a configuration change empties the store
   a_r11_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(buf_mode) || !$stable(res_hi)) |=> (level == '0));
endmodule

bind accel_sample_buffer smpbuf_chk #(.CAP_LO(CAP_NARROW), .CAP_HI(CAP_WIDE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .buf_mode  (buf_mode),
   .res_hi    (res_hi),
   .smp_valid (smp_valid),
   .rd_strobe (rd_strobe),
   .level     (level),
   .full      (full),
   .rd_byte   (rd_byte)
);

// File: tb/sim_accel_sample_buffer.sv
module sim_accel_sample_buffer;
   localparam int CLK_P = 10;
   localparam int CAP8  = 84;
   localparam int CAP12 = 41;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [11:0] smp_x = '0, smp_y = '0, smp_z = '0;
   logic        res_hi = 1'b0;
   logic [1:0]  buf_mode = 2'd0;
   logic [6:0]  wm_level = 7'd5;
   logic        trig_evt = 1'b0;
   logic        rd_strobe = 1'b0;
   logic [7:0]  rd_byte;
   logic [6:0]  level;
   logic        wmark, full;

   int checks = 0;
   int errors = 0;
   bit run_cmp = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   accel_sample_buffer u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
      .res_hi(res_hi), .buf_mode(buf_mode), .wm_level(wm_level),
      .trig_evt(trig_evt), .rd_strobe(rd_strobe),
      .rd_byte(rd_byte), .level(level), .wmark(wmark), .full(full)
   );

   function automatic logic [11:0] vx(int n); return 12'(n*151 + 7);   endfunction
   function automatic logic [11:0] vy(int n); return 12'(n*89 + 1000); endfunction
   function automatic logic [11:0] vz(int n); return 12'(n*233 + 3);   endfunction
   function automatic logic [7:0] hb(logic [11:0] v); return v[11:4]; endfunction
   function automatic logic [7:0] lb(logic [11:0] v); return {v[3:0], 4'h0}; endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [7:0] mq[$];
   int  m_cnt, m_hs, m_bps, m_cap, m_lim;
   bit  m_trg, m_take, m_disc, m_done;
   logic [1:0] m_mode;
   bit  m_res;
   logic [7:0] e_rd;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mq.delete(); m_cnt = 0; m_hs = 0; m_trg = 0;
         m_mode = 0; m_res = 0; e_rd = 0;
      end else if (buf_mode != m_mode || res_hi != m_res) begin
         mq.delete(); m_cnt = 0; m_hs = 0; m_trg = 0;
         m_mode = buf_mode; m_res = res_hi;
      end else begin
         m_bps = res_hi ? 6 : 3;
         m_cap = res_hi ? CAP12 : CAP8;
         m_lim = (int'(wm_level) < m_cap) ? int'(wm_level) : m_cap;
         m_take = 0; m_disc = 0; m_done = 0;
         if (buf_mode == 2'd1) begin
            m_take = smp_valid; m_disc = smp_valid && (m_cnt == m_cap);
         end else if (buf_mode == 2'd2 && !(m_trg || trig_evt)) begin
            m_take = smp_valid && (wm_level != 0);
            m_disc = m_take && (m_cnt >= m_lim);
         end else begin
            m_take = smp_valid && (m_cnt != m_cap);
         end
         if (rd_strobe) begin
            if (m_cnt > 0) begin
               e_rd = mq.pop_front(); m_hs++;
               if (m_hs == m_bps) begin m_hs = 0; m_done = 1; end
            end else e_rd = 0;
         end
         if (m_disc && !m_done) begin
            repeat (m_bps - m_hs) void'(mq.pop_front());
            m_hs = 0; m_done = 1;
         end
         if (m_done) m_cnt--;
         if (m_take) begin
            if (res_hi) begin
               mq.push_back(lb(smp_x)); mq.push_back(hb(smp_x));
               mq.push_back(lb(smp_y)); mq.push_back(hb(smp_y));
               mq.push_back(lb(smp_z)); mq.push_back(hb(smp_z));
            end else begin
               mq.push_back(hb(smp_x)); mq.push_back(hb(smp_y)); mq.push_back(hb(smp_z));
            end
            m_cnt++;
         end
         if (trig_evt) m_trg = 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && run_cmp) begin
         chk("R9 rd_byte vs model", rd_byte, e_rd);
         chk("R2 level vs model", level, m_cnt);
         chk("R2 full vs model", full, int'(m_cnt == (res_hi ? CAP12 : CAP8)));
         chk("R6 wmark vs model", wmark,
             int'((buf_mode != 2'd2) && (wm_level != 0) && (m_cnt >= int'(wm_level))));
      end
   end

   // ---------------- stimulus ----------------
   task automatic step();
      @(posedge clk); #(CLK_P/4);
   endtask

   task automatic put(input int n);
      smp_valid = 1'b1; smp_x = vx(n); smp_y = vy(n); smp_z = vz(n);
      step();
      smp_valid = 1'b0;
   endtask

   task automatic rd1();
      rd_strobe = 1'b1; step(); rd_strobe = 1'b0;
   endtask

   initial begin
      #(CLK_P*150000);
      errors++;
      $display("FAIL R1 watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) step();
      chk("R1 reset level", level, 0);
      chk("R1 reset full", full, 0);
      chk("R1 reset wmark", wmark, 0);
      chk("R1 reset rd_byte", rd_byte, 0);
      rst_n = 1'b1; run_cmp = 1'b1;
      step();

      // narrow packing and reads
      put(1); put(2);
      chk("R9 level two samples", level, 2);
      rd1(); chk("R3 narrow X", rd_byte, hb(vx(1)));
      rd1(); chk("R3 narrow Y", rd_byte, hb(vy(1)));
      step(); chk("R9 rd_byte held", rd_byte, hb(vy(1)));
      rd1(); chk("R3 narrow Z", rd_byte, hb(vz(1)));
      chk("R9 level after sample read", level, 1);

      // watermark
      wm_level = 7'd3; put(3); put(4);
      chk("R6 wmark at threshold", wmark, 1);
      rd1(); rd1(); chk("R6 wmark held mid sample", wmark, 1);
      rd1(); chk("R6 wmark drops below", wmark, 0);

      // queue fill
      for (int i = 0; i < 90; i++) put(10 + i);
      chk("R2 narrow capacity", level, CAP8);
      chk("R4 full flag", full, 1);
      rd1(); chk("R4 oldest kept", rd_byte, hb(vx(3)));

      // wide resolution
      res_hi = 1'b1; step();
      chk("R11 flush on res change", level, 0);
      put(50);
      rd1(); chk("R3 wide X low", rd_byte, lb(vx(50)));
      rd1(); chk("R3 wide X high", rd_byte, hb(vx(50)));
      rd1(); chk("R3 wide Y low", rd_byte, lb(vy(50)));
      for (int i = 0; i < 45; i++) put(60 + i);
      chk("R2 wide capacity", level, CAP12);
      chk("R2 wide full", full, 1);

      // streaming
      buf_mode = 2'd1; res_hi = 1'b0; step();
      for (int i = 0; i < CAP8; i++) put(100 + i);
      rd1(); chk("R5 head first byte", rd_byte, hb(vx(100)));
      put(200);
      chk("R5 level stays at capacity", level, CAP8);
      rd1(); chk("R5 partly read head evicted", rd_byte, hb(vx(101)));

      // simultaneous read and write
      buf_mode = 2'd0; step();
      for (int i = 0; i < CAP8; i++) put(400 + i);
      rd1(); rd1();
      rd_strobe = 1'b1; smp_valid = 1'b1; smp_x = vx(500); smp_y = vy(500); smp_z = vz(500);
      step(); rd_strobe = 1'b0; smp_valid = 1'b0;
      chk("R12 full-queue sample dropped", level, CAP8 - 1);
      rd_strobe = 1'b1; smp_valid = 1'b1; smp_x = vx(501); smp_y = vy(501); smp_z = vz(501);
      step(); rd_strobe = 1'b0; smp_valid = 1'b0;
      chk("R12 read and write together", level, CAP8);
      chk("R12 byte read alongside write", rd_byte, hb(vx(401)));

      // capture mode
      buf_mode = 2'd2; wm_level = 7'd4; step();
      for (int i = 0; i < 10; i++) put(300 + i);
      chk("R7 history limit", level, 4);
      chk("R6 no wmark in capture", wmark, 0);
      rd1(); chk("R7 newest kept", rd_byte, hb(vx(306)));
      trig_evt = 1'b1; put(310); trig_evt = 1'b0;
      chk("R8 trigger sample kept", level, 5);
      for (int i = 0; i < 100; i++) put(320 + i);
      chk("R8 fills to capacity", level, CAP8);
      chk("R8 full after trigger", full, 1);

      buf_mode = 2'd0; step();
      buf_mode = 2'd2; wm_level = 7'd0; step();
      put(1); put(2); put(3);
      chk("R7 zero threshold stores nothing", level, 0);

      // empty read
      buf_mode = 2'd0; wm_level = 7'd5; step();
      rd1(); chk("R10 empty read zero", rd_byte, 0);
      chk("R10 level unchanged", level, 0);
      put(600);
      rd1(); chk("R10 pointer not moved", rd_byte, hb(vx(600)));

      // mixed traffic against the model
      for (int c = 0; c < 4000; c++) begin
         smp_valid = ($urandom % 3) != 0;
         smp_x = 12'($urandom); smp_y = 12'($urandom); smp_z = 12'($urandom);
         rd_strobe = ($urandom % 2) != 0;
         trig_evt  = ($urandom % 60) == 0;
         if (($urandom % 250) == 0) buf_mode = 2'($urandom);
         if (($urandom % 400) == 0) res_hi = ~res_hi;
         if (($urandom % 150) == 0) wm_level = 7'($urandom % 90);
         step();
      end
      smp_valid = 1'b0; rd_strobe = 1'b0; trig_evt = 1'b0;
      step(); step();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule